// File: doc/BRIEF.md
# SPI Master with Programmable Select Timing

This block is a single-channel serial peripheral master that runs from the system clock. It drives a serial clock whose period is set by an 8-bit prescale value, one active-low select line, a data output, and a data input that it samples. Each transfer moves one word, most significant bit first. The word length is a parameter and defaults to 16 bits. Both serial clock idle levels are supported. Data is always presented half a bit ahead of the edge that samples it. Two programmable delay fields set the time from select assertion to the first serial clock edge and the time from the last serial clock edge to select release.

The host places the configuration and transmit word on parallel inputs and raises `start`. The block copies everything it needs at that moment, raises `busy`, and at the end of the transfer gives a single-cycle `done` pulse together with the received word. When the select-keep option is set and `start` is present at the end of the release wait, the block does not release the select line. It goes straight into the next word.

Top module: `spim_master`

## Requirements
- R1: For a prescale value PS from 1 to 255, the interval between successive sampling edges of the serial clock is PS+1 system clock cycles.
- R2: For a prescale value of 0, the interval between successive sampling edges is 2 system clock cycles.
- R3: Within each bit, the serial clock spends floor(P/2) cycles at high level and P-floor(P/2) cycles at low level, where P is the period from R1/R2. When P is odd, the extra cycle falls in the low level.
- R4: While idle, the select line is high (1), `busy` is 0, and the serial clock rests at the polarity input (0 or 1). A change of that input reaches the serial clock one cycle later.
- R5: With select-keep clear, the first serial clock edge follows the select falling edge by lead-delay+2 cycles.
- R6: With select-keep set, the first serial clock edge follows the select falling edge by lead-delay+3 cycles.
- R7: Select rises exactly rest-phase+lag-delay+1 cycles after the last serial clock edge, where rest-phase is the number of cycles the clock spends at its idle level in a bit. At that moment the clock is at its idle level.
- R8: A transfer has exactly 2×word-length serial clock edges. The sampling edge is rising for polarity 0 and falling for polarity 1. The data output carries the transmit word MSB first from the select falling edge, and it changes only on the edges that return the clock to its idle level.
- R9: The received word is the input bit sampled at each sampling edge, first sample in the MSB. It appears on `rx_data` in the same cycle as the `done` pulse.
- R10: `busy` rises the cycle after `start` is accepted while idle. `done` is a one-cycle pulse. On a transfer that does not chain, `done` coincides with select release and `busy` falling.
- R11: With select-keep set and `start` present on the last cycle of the release wait, select stays low and `done` pulses with `busy` still high. The next word's first edge then comes lead-delay+2+keep cycles after that `done`, using the newly sampled settings.
- R12: With select-keep clear, `start` held during the release wait does not prolong the transfer. Select rises on schedule and `busy` falls.
- R13: Configuration and transmit inputs are captured when `start` is accepted. Changes to them during a transfer have no effect on that transfer's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_prescale | input | PS_W | Prescale value PS |
| cfg_cs_keep | input | 1 | Keep select asserted between chained words |
| cfg_lead_dly | input | DLY_W | Select-to-first-edge delay field |
| cfg_lag_dly | input | DLY_W | Last-edge-to-release delay field |
| start | input | 1 | Transfer request |
| tx_data | input | DATA_W | Word to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_data | output | DATA_W | Received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The sweep covers every combination of both polarities and both select-keep settings with prescale values 0, 1, 2, 3, 4, 7, 8 and 255, several lead delays and two lag delays. The even and odd prescale values distinguish where the extra cycle falls, 0 against 1 exposes the special case, and 255 exercises the widest period. Transmit and slave-return patterns vary per word and include all-zeros, all-ones and alternating bits, so a bit-order or capture-edge slip changes the result. Separate runs chain two words with select-keep set and with it clear, and alter every setting mid-transfer to show that the captured settings govern.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    SP_IDLE,
    SP_LEAD,
    SP_ACT,
    SP_REST,
    SP_LAG
  } spim_state_e;
endpackage

// File: rtl/spim_rst_sync.sv
module spim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/spim_timing.sv
// Converts the settings of one transfer into counter reload values (length-1).
module spim_timing #(
  parameter int PS_W  = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             cpol,
  input  logic [PS_W-1:0]  prescale,
  input  logic             keep,
  input  logic [DLY_W-1:0] lead_dly,
  input  logic [DLY_W-1:0] lag_dly,
  output logic [CNT_W-1:0] lead_m1,
  output logic [CNT_W-1:0] act_m1,
  output logic [CNT_W-1:0] rest_m1,
  output logic [CNT_W-1:0] lag_m1
);
  localparam int PW = PS_W + 1;

  logic [PW-1:0] period;
  logic [PW-1:0] high_len;
  logic [PW-1:0] low_len;
  logic [PW-1:0] act_len;
  logic [PW-1:0] rest_len;

  always_comb begin
    period   = (prescale == '0) ? PW'(2) : PW'(prescale) + PW'(1);
    high_len = period >> 1;
    low_len  = period - high_len;
    // the sampling half sits at the non-idle level
    act_len  = cpol ? low_len  : high_len;
    rest_len = cpol ? high_len : low_len;
    act_m1   = CNT_W'(act_len)  - CNT_W'(1);
    rest_m1  = CNT_W'(rest_len) - CNT_W'(1);
    lead_m1  = CNT_W'(lead_dly) + CNT_W'(1) + CNT_W'(keep);
    lag_m1   = CNT_W'(rest_len) + CNT_W'(lag_dly);
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_en,
  input  logic              cap_en,
  input  logic              present_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] out_q, out_d;

  always_comb begin
    tx_d = tx_q;
    if (load_en)       tx_d = load_word;
    else if (shift_en) tx_d = {tx_q[DATA_W-2:0], 1'b0};
    rx_d  = cap_en ? {rx_q[DATA_W-2:0], miso} : rx_q;
    out_d = present_en ? rx_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      out_q <= out_d;
    end
  end

  assign mosi    = tx_q[DATA_W-1];
  assign rx_word = out_q;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PS_W   = 8,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic [PS_W-1:0]  cfg_prescale,
  input  logic             cfg_keep,
  input  logic [DLY_W-1:0] cfg_lead,
  input  logic [DLY_W-1:0] cfg_lag,
  input  logic [CNT_W-1:0] lead_m1,
  input  logic [CNT_W-1:0] act_m1,
  input  logic [CNT_W-1:0] rest_m1,
  input  logic [CNT_W-1:0] lag_m1,
  output logic             accept,
  output logic             cpol_q,
  output logic [PS_W-1:0]  prescale_q,
  output logic             keep_q,
  output logic [DLY_W-1:0] lead_q,
  output logic [DLY_W-1:0] lag_q,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic             load_en,
  output logic             shift_en,
  output logic             cap_en,
  output logic             present_en
);
  localparam int BW = $clog2(DATA_W + 1);

  spim_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]    bits_q, bits_d;
  logic             sclk_q, sclk_d;
  logic             cs_q, cs_d;
  logic             done_q, done_d;
  logic             cpol_d, keep_d;
  logic [PS_W-1:0]  prescale_d;
  logic [DLY_W-1:0] lead_d, lag_d;

  always_comb begin
    st_d       = st_q;
    cnt_d      = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
    bits_d     = bits_q;
    sclk_d     = sclk_q;
    cs_d       = cs_q;
    done_d     = 1'b0;
    accept     = 1'b0;
    load_en    = 1'b0;
    shift_en   = 1'b0;
    cap_en     = 1'b0;
    present_en = 1'b0;
    unique case (st_q)
      SP_IDLE: begin
        sclk_d = cfg_cpol;
        if (start) begin
          accept  = 1'b1;
          load_en = 1'b1;
          cs_d    = 1'b0;
          cnt_d   = lead_m1;
          bits_d  = '0;
          st_d    = SP_LEAD;
        end
      end
      SP_LEAD, SP_REST: begin
        if (cnt_q == '0) begin
          sclk_d = ~sclk_q;
          cap_en = 1'b1;
          bits_d = bits_q + BW'(1);
          cnt_d  = act_m1;
          st_d   = SP_ACT;
        end
      end
      SP_ACT: begin
        if (cnt_q == '0) begin
          sclk_d = ~sclk_q;
          if (bits_q == BW'(DATA_W)) begin
            cnt_d = lag_m1;
            st_d  = SP_LAG;
          end else begin
            shift_en = 1'b1;
            cnt_d    = rest_m1;
            st_d     = SP_REST;
          end
        end
      end
      SP_LAG: begin
        if (cnt_q == '0) begin
          done_d     = 1'b1;
          present_en = 1'b1;
          if (keep_q && start) begin
            accept  = 1'b1;
            load_en = 1'b1;
            cnt_d   = lead_m1;
            bits_d  = '0;
            st_d    = SP_LEAD;
          end else begin
            cs_d = 1'b1;
            st_d = SP_IDLE;
          end
        end
      end
      default: st_d = SP_IDLE;
    endcase
  end

  always_comb begin
    cpol_d     = accept ? cfg_cpol     : cpol_q;
    prescale_d = accept ? cfg_prescale : prescale_q;
    keep_d     = accept ? cfg_keep     : keep_q;
    lead_d     = accept ? cfg_lead     : lead_q;
    lag_d      = accept ? cfg_lag      : lag_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SP_IDLE;
      cnt_q      <= '0;
      bits_q     <= '0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      done_q     <= 1'b0;
      cpol_q     <= 1'b0;
      prescale_q <= '0;
      keep_q     <= 1'b0;
      lead_q     <= '0;
      lag_q      <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      bits_q     <= bits_d;
      sclk_q     <= sclk_d;
      cs_q       <= cs_d;
      done_q     <= done_d;
      cpol_q     <= cpol_d;
      prescale_q <= prescale_d;
      keep_q     <= keep_d;
      lead_q     <= lead_d;
      lag_q      <= lag_d;
    end
  end

  assign busy = (st_q != SP_IDLE);
  assign done = done_q;
  assign sclk = sclk_q;
  assign cs_n = cs_q;
endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int DATA_W = 16,
  parameter int PS_W   = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic [PS_W-1:0]   cfg_prescale,
  input  logic              cfg_cs_keep,
  input  logic [DLY_W-1:0]  cfg_lead_dly,
  input  logic [DLY_W-1:0]  cfg_lag_dly,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int CNT_W = ((PS_W > DLY_W) ? PS_W : DLY_W) + 2;

  logic             rst_i_n;
  logic             accept;
  logic             cpol_q, keep_q;
  logic [PS_W-1:0]  prescale_q;
  logic [DLY_W-1:0] lead_q, lag_q;
  logic             use_cpol, use_keep;
  logic [PS_W-1:0]  use_prescale;
  logic [DLY_W-1:0] use_lead, use_lag;
  logic [CNT_W-1:0] lead_m1, act_m1, rest_m1, lag_m1;
  logic             load_en, shift_en, cap_en, present_en;

  spim_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // on the accepting cycle the counter reload comes from the live settings
  always_comb begin
    use_cpol     = accept ? cfg_cpol     : cpol_q;
    use_prescale = accept ? cfg_prescale : prescale_q;
    use_keep     = accept ? cfg_cs_keep  : keep_q;
    use_lead     = accept ? cfg_lead_dly : lead_q;
    use_lag      = accept ? cfg_lag_dly  : lag_q;
  end

  spim_timing #(.PS_W(PS_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_timing (
    .cpol     (use_cpol),
    .prescale (use_prescale),
    .keep     (use_keep),
    .lead_dly (use_lead),
    .lag_dly  (use_lag),
    .lead_m1  (lead_m1),
    .act_m1   (act_m1),
    .rest_m1  (rest_m1),
    .lag_m1   (lag_m1)
  );

  spim_ctrl #(.DATA_W(DATA_W), .PS_W(PS_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_i_n),
    .start        (start),
    .cfg_cpol     (cfg_cpol),
    .cfg_prescale (cfg_prescale),
    .cfg_keep     (cfg_cs_keep),
    .cfg_lead     (cfg_lead_dly),
    .cfg_lag      (cfg_lag_dly),
    .lead_m1      (lead_m1),
    .act_m1       (act_m1),
    .rest_m1      (rest_m1),
    .lag_m1       (lag_m1),
    .accept       (accept),
    .cpol_q       (cpol_q),
    .prescale_q   (prescale_q),
    .keep_q       (keep_q),
    .lead_q       (lead_q),
    .lag_q        (lag_q),
    .busy         (busy),
    .done         (done),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .load_en      (load_en),
    .shift_en     (shift_en),
    .cap_en       (cap_en),
    .present_en   (present_en)
  );

  spim_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_ni     (rst_i_n),
    .load_en    (load_en),
    .load_word  (tx_data),
    .shift_en   (shift_en),
    .cap_en     (cap_en),
    .present_en (present_en),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_data)
  );
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic cpol_lat
);
  // R4: select never asserted while idle
  p_idle_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R10: done lasts a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a final done coincides with release
  p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy) |-> cs_n);

  // R11: a chained done keeps select low
  p_chain_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |-> !cs_n);

  // R7: clock at its idle level when select rises
  p_rest_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk == cpol_lat));

  // R8: data output moves only on the edge back to idle level
  p_mosi_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done && !$stable(mosi))
      |-> (sclk == cpol_lat && $past(sclk) != cpol_lat));

  // R10: an idle start is taken
  p_start_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !done) |=> busy);
endmodule

bind spim_master spim_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .cpol_lat (cpol_q)
);

// File: tb/spim_master_tb_top.sv
`timescale 1ns/1ps
module spim_master_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0;
  logic [7:0] cfg_prescale = '0;
  logic       cfg_cs_keep = 1'b0;
  logic [7:0] cfg_lead_dly = '0;
  logic [7:0] cfg_lag_dly = '0;
  logic       start = 1'b0;
  logic [N-1:0] tx_data = '0;
  logic       busy, done, sclk, cs_n, mosi;
  logic       miso = 1'b0;
  logic [N-1:0] rx_data;

  int vec = 0;
  int err = 0;

  always #4 clk = ~clk;

  spim_master #(.DATA_W(N), .PS_W(8), .DLY_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_prescale(cfg_prescale),
    .cfg_cs_keep(cfg_cs_keep), .cfg_lead_dly(cfg_lead_dly), .cfg_lag_dly(cfg_lag_dly),
    .start(start), .tx_data(tx_data), .busy(busy), .done(done), .rx_data(rx_data),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // ---------------- monitor and slave model ----------------
  logic       mon_clr = 1'b0;
  logic       cpol_m = 1'b0;
  logic [N-1:0] pat_m [0:1];
  int cyc = 0, ne = 0, nc = 0, nf = 0, nr = 0, nd = 0, ntrail = 0;
  int et [0:63];
  int cf_t [0:3];
  int cr_t [0:3];
  int dn_t [0:3];
  logic cap_b [0:31];
  logic sclk_p = 1'b0, cs_p = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      ne = 0; nc = 0; nf = 0; nr = 0; nd = 0; ntrail = 0;
    end else begin
      if (!cs_n && sclk !== sclk_p && ne < 64) begin
        et[ne] = cyc; ne++;
        if (sclk !== cpol_m) begin
          if (nc < 32) cap_b[nc] = mosi;
          nc++;
        end else ntrail++;
      end
      if (cs_p && !cs_n && nf < 4) begin cf_t[nf] = cyc; nf++; end
      if (!cs_p && cs_n && nr < 4) begin cr_t[nr] = cyc; nr++; end
      if (done && nd < 4) begin dn_t[nd] = cyc; nd++; end
    end
    sclk_p = sclk;
    cs_p   = cs_n;
    miso   = (ntrail < 2*N) ? pat_m[ntrail/N][N-1-(ntrail%N)] : 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_of(input int ps);
    return (ps == 0) ? 2 : ps + 1;
  endfunction

  // checks on the edges of one word starting at edge index b
  task automatic chk_word_timing(input int b, input int cpol, input int ps, input int lg,
                                 input logic [N-1:0] tx, input int rel_t, input string tag);
    int p = per_of(ps);
    int hi = p / 2;
    int lo = p - hi;
    int act = cpol ? lo : hi;
    int rst_len = cpol ? hi : lo;
    int per_bad = 0, ph_bad = 0, bit_bad = 0;
    for (int k = 0; k < N; k++) begin
      if (et[b+2*k+1] - et[b+2*k] != act) ph_bad++;
      if (k < N-1) begin
        if (et[b+2*k+2] - et[b+2*k+1] != rst_len) ph_bad++;
        if (et[b+2*k+2] - et[b+2*k] != p) per_bad++;
      end
      if (cap_b[b/2+k] !== tx[N-1-k]) bit_bad++;
    end
    chk((ps == 0) ? {"R2 period ", tag} : {"R1 period ", tag}, per_bad, 0);
    chk({"R3 phase split ", tag}, ph_bad, 0);
    chk({"R8 mosi bits ", tag}, bit_bad, 0);
    chk({"R7 lag ", tag}, rel_t - et[b+2*N-1], rst_len + lg + 1);
  endtask

  task automatic set_cfg(input int cpol, input int ps, input int keep, input int ld, input int lg);
    cfg_cpol = cpol[0]; cfg_prescale = 8'(ps); cfg_cs_keep = keep[0];
    cfg_lead_dly = 8'(ld); cfg_lag_dly = 8'(lg);
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #1; end while (!done);
  endtask

  task automatic run_one(input int cpol, input int ps, input int keep, input int ld,
                         input int lg, input logic [N-1:0] tx, input logic [N-1:0] pat,
                         input bit mutate);
    string tag = mutate ? "R13" : "";
    set_cfg(cpol, ps, keep, ld, lg);
    tx_data = tx; pat_m[0] = pat; pat_m[1] = '0; cpol_m = cpol[0];
    @(posedge clk); #1;
    mon_clr = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    mon_clr = 1'b0; start = 1'b0;
    chk("R10 busy after start", int'(busy), 1);
    if (mutate) begin
      set_cfg(1 - cpol, (ps + 3) % 256, 1 - keep, ld + 4, lg + 5);
      tx_data = ~tx;
    end
    wait_done();
    chk({"R9 rx word ", tag}, int'(rx_data), int'(pat));
    chk("R10 busy low at done", int'(busy), 0);
    @(posedge clk); #1;
    chk("R10 done single", int'(done), 0);
    chk("R8 edge count", ne, 2*N);
    chk("R10 done with release", dn_t[0], cr_t[0]);
    chk(keep ? {"R6 lead ", tag} : {"R5 lead ", tag}, et[0] - cf_t[0], ld + 2 + keep);
    chk_word_timing(0, cpol, ps, lg, tx, cr_t[0], tag);
  endtask

  // two requests back to back; start held across the first word's release wait
  task automatic run_pair(input int keep, input int ps, input int ld, input int lg);
    logic [N-1:0] tx1 = 8'h3C, tx2 = 8'hD2;
    set_cfg(0, ps, keep, ld, lg);
    tx_data = tx1; pat_m[0] = 8'hA5; pat_m[1] = 8'h0F; cpol_m = 1'b0;
    @(posedge clk); #1;
    mon_clr = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    mon_clr = 1'b0; start = 1'b0;
    tx_data = tx2; start = 1'b1;
    wait_done();
    start = 1'b0;
    if (keep != 0) begin
      chk("R11 busy kept at chained done", int'(busy), 1);
      chk("R11 select low at chained done", int'(cs_n), 0);
      chk("R11 rx first word", int'(rx_data), 8'hA5);
      wait_done();
      chk("R11 rx second word", int'(rx_data), 8'h0F);
      @(posedge clk); #1;
      chk("R11 one select fall", nf, 1);
      chk("R11 one select rise", nr, 1);
      chk("R11 chained lead", et[2*N] - dn_t[0], ld + 2 + 1);
      chk_word_timing(2*N, 0, ps, lg, tx2, cr_t[0], "R11");
    end else begin
      chk("R12 busy low at done", int'(busy), 0);
      chk("R12 select released", int'(cs_n), 1);
      chk("R12 rx word", int'(rx_data), 8'hA5);
      repeat (3) @(posedge clk); #1;
      chk("R12 no second word", int'(busy), 0);
      chk("R12 release on schedule", cr_t[0] - et[2*N-1], (per_of(ps) - per_of(ps)/2) + lg + 1);
    end
  endtask

  initial begin
    int ps_l [0:7] = '{0, 1, 2, 3, 4, 7, 8, 255};
    int ld_l [0:2] = '{0, 1, 6};
    int idx = 0;
    pat_m[0] = '0; pat_m[1] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R4 reset select", int'(cs_n), 1);
    chk("R4 reset clock", int'(sclk), 0);
    chk("R4 reset busy", int'(busy), 0);
    chk("R10 reset done", int'(done), 0);
    cfg_cpol = 1'b1;
    @(posedge clk); #1;
    chk("R4 idle level follows polarity", int'(sclk), 1);
    cfg_cpol = 1'b0;
    @(posedge clk); #1;
    chk("R4 idle level back to 0", int'(sclk), 0);

    for (int pi = 0; pi < 8; pi++)
      for (int cp = 0; cp < 2; cp++)
        for (int kp = 0; kp < 2; kp++)
          for (int li = 0; li < 3; li++)
            for (int lg = 0; lg < 4; lg += 3) begin
              logic [N-1:0] tx, pt;
              tx = N'(idx * 53 + 17);
              pt = N'(idx * 29 + 90);
              if (idx % 7 == 0) begin tx = '1; pt = '0; end
              if (idx % 7 == 3) begin tx = 8'h55; pt = 8'hAA; end
              run_one(cp, ps_l[pi], kp, ld_l[li], lg, tx, pt, 1'b0);
              idx++;
            end

    run_one(0, 3, 0, 2, 1, 8'hC3, 8'h5A, 1'b1);
    run_one(1, 4, 1, 1, 2, 8'h81, 8'h7E, 1'b1);
    run_pair(1, 2, 3, 1);
    run_pair(1, 0, 0, 0);
    run_pair(0, 3, 1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule